// File: doc/BRIEF.md
# Cache-Line Data ECC Checker (72/64 SEC-DED classification)

This block checks the data of one cache line, one doubleword at a time. Each doubleword arrives as 64 data bits together with the 8-bit check byte stored beside it. The block computes eight check bits from the data. Each check bit is the parity of the data bits picked out by its own 64-bit mask. All eight masks are byte rotations of one seed constant. The block then compares the result with the stored byte.

The difference between the two bytes is the syndrome. The block sorts each word into one of three classes, using only the number of ones in the syndrome: clean, single-bit error or multi-bit error. It also tracks where each word sits in its line. It builds a map of which words of the line were bad, keeps sticky single-bit and multi-bit flags for the line, and pulses a done strobe once the last word of the line has been accepted.

Fault-handling logic uses the map and flags to decide between scrubbing and escalating. The block does not correct data and does not locate the failing bit.

Top module: `line_ecc_checker`

## Requirements
- R1: Check bit i (i = 0..7) is the XOR of the data bits selected by mask i. Mask 0 is 0x0738C808099264FF, and mask i is mask 0 rotated left by 8*i bits. For example, data 0x1 has check byte 0x23.
- R2: A syndrome of zero (computed XOR stored) gives class code 2'b00 (clean).
- R3: A syndrome with exactly one bit set gives class code 2'b01 (single-bit).
- R4: Any other nonzero syndrome gives class code 2'b10 (multi-bit). Code 2'b11 never appears.
- R5: Results are registered. After a clock edge where `dw_valid_i` was high, `res_valid_o` is high and `res_class_o` holds that word's class for one cycle. After an edge where `dw_valid_i` was low, `res_valid_o` is low and `res_class_o` is 2'b00.
- R6: Accepted words take line offsets 0..3 in order. A word with a nonzero syndrome sets bit (3 - offset) of `bad_map_o`, so offset 0 is the most significant bit.
- R7: `line_start_i` clears the map and both sticky flags. When it is high together with `dw_valid_i`, that word is offset 0 and is counted in the freshly cleared line. When it is high alone, the next accepted word is offset 0.
- R8: `sbe_seen_o` and `mbe_seen_o` are the OR, over the words accepted so far in the line, of "class was single" and "class was multi".
- R9: `line_done_o` is high for exactly one cycle, the one after the offset-3 word is accepted. The word after that begins a new line, with the map and flags cleared, even without `line_start_i`.
- R10: After reset, all outputs are 0 and the next accepted word is offset 0.
- R11: Cycles with `dw_valid_i` and `line_start_i` both low leave the map, the flags and the offset unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start_i | input | 1 | Begin a new line (clears map and flags) |
| dw_valid_i | input | 1 | Data/check pair is valid this cycle |
| dw_data_i | input | 64 | Data doubleword |
| dw_check_i | input | 8 | Stored check byte |
| res_valid_o | output | 1 | Registered result valid |
| res_class_o | output | 2 | 00 clean, 01 single-bit, 10 multi-bit |
| bad_map_o | output | 4 | Per-offset bad-ECC map, offset 0 at MSB |
| sbe_seen_o | output | 1 | Sticky single-bit flag for the line |
| mbe_seen_o | output | 1 | Sticky multi-bit flag for the line |
| line_done_o | output | 1 | Pulse after the last word of a line |

## Verification
The bench builds the block with its default parameters: four words per line and the standard seed mask. That makes the offset wrap and the MSB-first map positions reachable in a handful of cycles. The reference model recomputes the masks by rotation and the syndrome weight by counting bits, so each class is hit from flipped check bits and also from flipped data bits. Gaps with valid low, a line start on its own, a start arriving mid-line and lines that run on without a start are all mixed into a long random stream.

// File: rtl/line_ecc_pkg.sv
package line_ecc_pkg;

    localparam int DW_BITS  = 64;
    localparam int CHK_BITS = 8;
    localparam int ROT_STEP = DW_BITS / CHK_BITS;
    localparam int CNT_W    = $clog2(CHK_BITS + 1);

    localparam logic [DW_BITS-1:0] DEFAULT_SEED = 64'h0738C808099264FF;

    typedef enum logic [1:0] {
        ECC_NONE   = 2'b00,
        ECC_SINGLE = 2'b01,
        ECC_MULTI  = 2'b10
    } ecc_class_e;

    // Rotate the seed left by ROT_STEP bits, 'steps' times.
    function automatic logic [DW_BITS-1:0] rot_mask(input logic [DW_BITS-1:0] seed,
                                                    input int steps);
        logic [DW_BITS-1:0] m;
        m = seed;
        for (int k = 0; k < steps; k++) begin
            m = {m[DW_BITS-ROT_STEP-1:0], m[DW_BITS-1:DW_BITS-ROT_STEP]};
        end
        return m;
    endfunction

endpackage

// File: rtl/line_ecc_checkgen.sv
module line_ecc_checkgen
    import line_ecc_pkg::*;
#(
    parameter logic [DW_BITS-1:0] MASK_SEED = DEFAULT_SEED
) (
    input  logic [DW_BITS-1:0]  data_i,
    output logic [CHK_BITS-1:0] check_o
);

    for (genvar gi = 0; gi < CHK_BITS; gi++) begin : g_bit
        localparam logic [DW_BITS-1:0] MASK_I = rot_mask(MASK_SEED, gi);
        assign check_o[gi] = ^(data_i & MASK_I);
    end

endmodule

// File: rtl/line_ecc_classify.sv
module line_ecc_classify
    import line_ecc_pkg::*;
(
    input  logic [CHK_BITS-1:0] computed_i,
    input  logic [CHK_BITS-1:0] stored_i,
    output ecc_class_e          class_o
);

    logic [CHK_BITS-1:0] syndrome;
    logic [CNT_W-1:0]    weight;

    always_comb begin
        syndrome = computed_i ^ stored_i;
        weight   = '0;
        for (int k = 0; k < CHK_BITS; k++) begin
            weight = weight + CNT_W'(syndrome[k]);
        end
        if (syndrome == '0) begin
            class_o = ECC_NONE;
        end else if (weight == CNT_W'(1)) begin
            class_o = ECC_SINGLE;
        end else begin
            class_o = ECC_MULTI;
        end
    end

endmodule

// File: rtl/line_ecc_checker.sv
module line_ecc_checker
    import line_ecc_pkg::*;
#(
    parameter int                 WORDS_PER_LINE = 4,
    parameter logic [DW_BITS-1:0] MASK_SEED      = DEFAULT_SEED
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      line_start_i,
    input  logic                      dw_valid_i,
    input  logic [DW_BITS-1:0]        dw_data_i,
    input  logic [CHK_BITS-1:0]       dw_check_i,
    output logic                      res_valid_o,
    output logic [1:0]                res_class_o,
    output logic [WORDS_PER_LINE-1:0] bad_map_o,
    output logic                      sbe_seen_o,
    output logic                      mbe_seen_o,
    output logic                      line_done_o
);

    localparam int               OFF_W    = $clog2(WORDS_PER_LINE);
    localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORDS_PER_LINE - 1);

    typedef struct packed {
        logic [OFF_W-1:0]          off;
        logic [WORDS_PER_LINE-1:0] map;
        logic                      sbe;
        logic                      mbe;
        logic                      vld;
        logic                      done;
        ecc_class_e                cls;
    } line_state_t;

    logic [CHK_BITS-1:0] computed;
    ecc_class_e          word_class;
    line_state_t         st_d, st_q;

    line_ecc_checkgen #(.MASK_SEED(MASK_SEED)) i_checkgen (
        .data_i  (dw_data_i),
        .check_o (computed)
    );

    line_ecc_classify i_classify (
        .computed_i (computed),
        .stored_i   (dw_check_i),
        .class_o    (word_class)
    );

    always_comb begin
        logic [OFF_W-1:0] eff_off;
        st_d      = st_q;
        st_d.vld  = dw_valid_i;
        st_d.done = 1'b0;
        st_d.cls  = ECC_NONE;
        eff_off   = line_start_i ? '0 : st_q.off;
        if (dw_valid_i) begin
            if (eff_off == '0) begin
                st_d.map = '0;
                st_d.sbe = 1'b0;
                st_d.mbe = 1'b0;
            end
            st_d.cls = word_class;
            if (word_class != ECC_NONE) begin
                st_d.map[LAST_OFF - eff_off] = 1'b1;
            end
            if (word_class == ECC_SINGLE) begin
                st_d.sbe = 1'b1;
            end
            if (word_class == ECC_MULTI) begin
                st_d.mbe = 1'b1;
            end
            st_d.done = (eff_off == LAST_OFF);
            st_d.off  = (eff_off == LAST_OFF) ? '0 : eff_off + OFF_W'(1);
        end else if (line_start_i) begin
            st_d.off = '0;
            st_d.map = '0;
            st_d.sbe = 1'b0;
            st_d.mbe = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{off: '0, map: '0, sbe: 1'b0, mbe: 1'b0,
                      vld: 1'b0, done: 1'b0, cls: ECC_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid_o = st_q.vld;
    assign res_class_o = st_q.cls;
    assign bad_map_o   = st_q.map;
    assign sbe_seen_o  = st_q.sbe;
    assign mbe_seen_o  = st_q.mbe;
    assign line_done_o = st_q.done;

endmodule

// File: rtl/line_ecc_checker_sva.sv
module line_ecc_checker_sva #(
    parameter int WORDS_PER_LINE = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      line_start_i,
    input logic                      dw_valid_i,
    input logic                      res_valid_o,
    input logic [1:0]                res_class_o,
    input logic [WORDS_PER_LINE-1:0] bad_map_o,
    input logic                      sbe_seen_o,
    input logic                      mbe_seen_o,
    input logic                      line_done_o
);

    assert_cls_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        res_class_o != 2'b11);

    assert_result_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dw_valid_i |=> res_valid_o);

    assert_no_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !dw_valid_i |=> (!res_valid_o && res_class_o == 2'b00));

    assert_map_marks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_class_o != 2'b00) |-> (bad_map_o != '0));

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start_i && !dw_valid_i) |=> (bad_map_o == '0 && !sbe_seen_o && !mbe_seen_o));

    assert_sticky_sbe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_class_o == 2'b01) |-> sbe_seen_o);

    assert_sticky_mbe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_class_o == 2'b10) |-> mbe_seen_o);

    assert_done_with_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        line_done_o |-> res_valid_o);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        line_done_o |=> !line_done_o);

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!dw_valid_i && !line_start_i) |=>
            ($stable(bad_map_o) && $stable(sbe_seen_o) && $stable(mbe_seen_o)));

endmodule

bind line_ecc_checker line_ecc_checker_sva #(.WORDS_PER_LINE(WORDS_PER_LINE)) i_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_start_i (line_start_i),
    .dw_valid_i   (dw_valid_i),
    .res_valid_o  (res_valid_o),
    .res_class_o  (res_class_o),
    .bad_map_o    (bad_map_o),
    .sbe_seen_o   (sbe_seen_o),
    .mbe_seen_o   (mbe_seen_o),
    .line_done_o  (line_done_o)
);

// File: tb/test_line_ecc_checker.sv
`timescale 1ns/1ps
module test_line_ecc_checker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start_i = 1'b0;
    logic        dw_valid_i = 1'b0;
    logic [63:0] dw_data_i = '0;
    logic [7:0]  dw_check_i = '0;
    logic        res_valid_o;
    logic [1:0]  res_class_o;
    logic [3:0]  bad_map_o;
    logic        sbe_seen_o, mbe_seen_o, line_done_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model state
    int       m_off = 0;
    logic [3:0] m_map = '0;
    logic     m_sbe = 0, m_mbe = 0, m_vld = 0, m_done = 0;
    logic [1:0] m_cls = '0;

    always #4 clk = ~clk;

    line_ecc_checker i_line_ecc_checker (
        .clk(clk), .rst_n(rst_n), .line_start_i(line_start_i),
        .dw_valid_i(dw_valid_i), .dw_data_i(dw_data_i), .dw_check_i(dw_check_i),
        .res_valid_o(res_valid_o), .res_class_o(res_class_o), .bad_map_o(bad_map_o),
        .sbe_seen_o(sbe_seen_o), .mbe_seen_o(mbe_seen_o), .line_done_o(line_done_o)
    );

    function automatic logic [7:0] ref_check(input logic [63:0] d);
        logic [63:0] m;
        logic [7:0]  p;
        m = 64'h0738C808099264FF;
        p = '0;
        for (int i = 0; i < 8; i++) begin
            int ones;
            ones = 0;
            for (int b = 0; b < 64; b++) if (m[b] && d[b]) ones++;
            p[i] = ones[0];
            m = (m << 8) | (m >> 56);
        end
        return p;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check("R5 res_valid", int'(res_valid_o), int'(m_vld));
        check("R2/R3/R4 class", int'(res_class_o), int'(m_cls));
        check("R6 bad_map", int'(bad_map_o), int'(m_map));
        check("R8 sbe_seen", int'(sbe_seen_o), int'(m_sbe));
        check("R8 mbe_seen", int'(mbe_seen_o), int'(m_mbe));
        check("R9 line_done", int'(line_done_o), int'(m_done));
    endtask

    task automatic model_update(input logic v, input logic s, input logic [63:0] d,
                                input logic [7:0] c);
        m_done = 0;
        m_cls  = 2'b00;
        m_vld  = v;
        if (v) begin
            int eo;
            logic [7:0] syn;
            eo = s ? 0 : m_off;
            if (eo == 0) begin m_map = '0; m_sbe = 0; m_mbe = 0; end
            syn = ref_check(d) ^ c;
            if (syn == 0) m_cls = 2'b00;
            else if ($countones(syn) == 1) m_cls = 2'b01;
            else m_cls = 2'b10;
            if (m_cls != 2'b00) m_map[3 - eo] = 1'b1;
            if (m_cls == 2'b01) m_sbe = 1;
            if (m_cls == 2'b10) m_mbe = 1;
            m_done = (eo == 3);
            m_off  = (eo + 1) % 4;
        end else if (s) begin
            m_off = 0; m_map = '0; m_sbe = 0; m_mbe = 0;
        end
    endtask

    // compare previous edge's result, then drive the next inputs
    task automatic step(input logic v, input logic s, input logic [63:0] d, input logic [7:0] c);
        @(negedge clk);
        compare_all();
        dw_valid_i = v; line_start_i = s; dw_data_i = d; dw_check_i = c;
        model_update(v, s, d, c);
    endtask

    task automatic word(input logic s, input logic [63:0] d, input logic [7:0] flip);
        step(1'b1, s, d, ref_check(d) ^ flip);
    endtask

    task automatic idle();
        step(1'b0, 1'b0, '0, '0);
    endtask

    task automatic after_edge_class(input string tag, input int exp);
        @(posedge clk);
        #1;
        check(tag, int'(res_class_o), exp);
    endtask

    initial begin
        #(8 * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        if (!finished) begin
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 reset valid", int'(res_valid_o), 0);
        check("R10 reset map", int'({bad_map_o, sbe_seen_o, mbe_seen_o, line_done_o}), 0);
        rst_n = 1'b1;

        // R1: fixed vectors, data 0x1 has check byte 0x23
        step(1'b1, 1'b1, 64'h1, 8'h23);
        after_edge_class("R1 R2 data=1 chk=23 clean", 0);
        step(1'b1, 1'b0, 64'h1, 8'h22);
        after_edge_class("R1 R3 data=1 chk=22 single", 1);
        step(1'b1, 1'b0, 64'h1, 8'h00);
        after_edge_class("R1 R4 data=1 chk=00 multi", 2);
        step(1'b1, 1'b0, 64'h0, 8'h00);
        after_edge_class("R2 zero word clean", 0);
        idle();

        // R6/R8/R9: line with single at offset 1, multi at offset 3
        word(1'b1, 64'hDEADBEEF01234567, 8'h00);
        word(1'b0, 64'h0123456789ABCDEF, 8'h01);
        word(1'b0, 64'hFFFFFFFFFFFFFFFF, 8'h00);
        word(1'b0, 64'h5555AAAA5555AAAA, 8'h03);
        idle();
        check("R6 map offsets 1,3", int'(bad_map_o), 4'b0101);

        // R11: gaps inside a line
        word(1'b1, 64'h1111, 8'h80);
        idle(); idle();
        word(1'b0, 64'h2222, 8'hFF);
        idle();
        word(1'b0, 64'h3333, 8'h00);
        word(1'b0, 64'h4444, 8'h00);
        // R9: wrap without start starts a new line
        word(1'b0, 64'h5555, 8'h00);
        word(1'b0, 64'h6666, 8'h10);
        idle();
        check("R9 wrap map", int'(bad_map_o), 4'b0100);

        // R7: start alone mid-line, then start with valid mid-line
        word(1'b1, 64'h7777, 8'h07);
        step(1'b0, 1'b1, '0, '0);
        idle();
        check("R7 start clears map", int'(bad_map_o), 0);
        word(1'b0, 64'h8888, 8'h04);
        word(1'b1, 64'h9999, 8'h00);
        idle();

        // R3/R4 via data-bit flips, stored check from original data
        for (int k = 0; k < 64; k += 7) begin
            logic [63:0] d;
            d = {$urandom, $urandom};
            step(1'b1, (k % 4) == 0, d ^ (64'h1 << k), ref_check(d));
        end

        // random stream
        for (int n = 0; n < 400; n++) begin
            int r;
            logic [7:0] flip;
            r = $urandom_range(0, 9);
            case ($urandom_range(0, 3))
                0: flip = 8'h00;
                1: flip = 8'h01 << $urandom_range(0, 7);
                2: flip = 8'($urandom);
                default: flip = 8'h00;
            endcase
            if (r < 2) step(1'b0, r == 0 && ($urandom_range(0, 3) == 0), '0, '0);
            else word($urandom_range(0, 7) == 0, {$urandom, $urandom}, flip);
        end
        idle();
        idle();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule